// File: doc/BRIEF.md
# Sequenced Integer ALU with Status Flags

This block performs one integer operation per request on two 16-bit operands, at either byte or word width, and produces the result together with an updated 16-bit status word. The supported operations are addition, subtraction, bitwise AND, increment and decrement. The arithmetic flags are computed from the operation at the selected width: carry/borrow, even parity, nibble carry, zero, sign and signed overflow. The control and unused bits of the incoming status word are carried through unchanged.

A small controller sequences each request. In `ST_IDLE` a `start` pulse captures the operation, width, operands and incoming status word, and moves to `ST_CALC` (transition IDLE→CALC). In `ST_CALC` the result and the new status word are registered, and the controller moves to `ST_DONE` (CALC→DONE). `ST_DONE` raises `done` for exactly one cycle and returns to `ST_IDLE` (DONE→IDLE). With no `start`, `ST_IDLE` holds (IDLE→IDLE). `busy` is high in `ST_CALC` and `ST_DONE`. Results stay on the outputs until the next request completes.

Top module: `alu_flags_unit`

## Requirements
- R1: After reset `busy` and `done` are 0, and `result` and `flags_out` are 0.
- R2: A `start` sampled while idle is accepted. `busy` is then high for two cycles, and `done` is high only in the second of them. A `start` sampled while `busy` is high has no effect on the result.
- R3: Op code 0 (ADD) gives a + b and op code 1 (SUB) gives a − b, modulo the width. The carry flag (bit 0) is the carry out of the top bit for ADD and the borrow (a < b unsigned) for SUB.
- R4: Op code 2 (AND) gives a & b and clears the carry (bit 0), auxiliary (bit 4) and overflow (bit 11) flags.
- R5: Op code 3 (INC) gives a + 1 and op code 4 (DEC) gives a − 1. Both leave the carry flag (bit 0) equal to bit 0 of `flags_in`.
- R6: For ADD, SUB, INC and DEC the auxiliary flag (bit 4) is the carry or borrow out of bit 3.
- R7: The sign flag (bit 7) is the top bit of the result at the selected width. The overflow flag (bit 11) is set when the signed result does not fit that width.
- R8: The zero flag (bit 6) is set when the result is 0 at the selected width. The parity flag (bit 2) is set when bits 7:0 of the result hold an even number of ones, also in word mode.
- R9: With `is_word` = 0 only bits 7:0 of the operands are used, `result[15:8]` is 0, and all flags are computed at 8 bits.
- R10: Bits 1, 3, 5, 8, 9, 10 and 12–15 of `flags_out` equal those bits of `flags_in` for every op code.
- R11: Op codes 5, 6 and 7 give `result` equal to operand a at the selected width, and `flags_out` equal to `flags_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, taken only when idle |
| op | input | 3 | Operation code (0 ADD, 1 SUB, 2 AND, 3 INC, 4 DEC) |
| is_word | input | 1 | 1 selects 16-bit operation, 0 selects 8-bit operation |
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand (ignored by INC and DEC) |
| flags_in | input | 16 | Current status word |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle pulse: result and flags are valid |
| result | output | 16 | Operation result |
| flags_out | output | 16 | Updated status word |

## Verification
On every completed request the checker module checks several flag rules. The zero and parity flags must match the result. The control and unused bits must equal the status word captured two cycles earlier. Byte mode must leave the upper result byte clear. AND must clear carry, overflow and nibble carry, INC and DEC must keep the carry flag, and `done` must be a single-cycle pulse. The arithmetic values themselves can only be shown by the bench's directed scenarios, which compare the outputs with an independent integer model. These values are the sums, the differences, the carry, borrow and signed-overflow boundaries at both widths, and the nibble carry. The same holds for the effect of a `start` issued while busy.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_INC = 3'd3,
        OP_DEC = 3'd4
    } alu_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CALC = 2'd1,
        ST_DONE = 2'd2
    } alu_state_e;

    // status word bit positions (fixed by the processor family)
    localparam int CF_POS = 0;
    localparam int PF_POS = 2;
    localparam int AF_POS = 4;
    localparam int ZF_POS = 6;
    localparam int SF_POS = 7;
    localparam int OF_POS = 11;

    typedef struct packed {
        logic carry;
        logic parity;
        logic aux;
        logic zero;
        logic sign;
        logic ovf;
    } arith_status_t;

endpackage

// File: rtl/alu_arith.sv
module alu_arith
    import alu_flags_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [2:0]        op,
    input  logic              is_word,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] res,
    output arith_status_t     st,
    output logic              op_known,
    output logic              keep_carry
);
    localparam int HALF_W = DATA_W / 2;
    localparam int MSB_IW = $clog2(DATA_W);

    logic [DATA_W-1:0] b_eff;
    logic              do_sub;
    logic [DATA_W:0]   word_sum;
    logic [HALF_W:0]   byte_sum;
    logic [DATA_W-1:0] arith_res;
    logic [DATA_W-1:0] and_res;
    logic [MSB_IW-1:0] top;
    logic              carry_raw;

    always_comb begin
        op_known   = (op <= OP_DEC);
        keep_carry = (op == OP_INC) || (op == OP_DEC);
        do_sub     = (op == OP_SUB) || (op == OP_DEC);
        b_eff      = keep_carry ? DATA_W'(1) : b;
        top        = is_word ? MSB_IW'(DATA_W - 1) : MSB_IW'(HALF_W - 1);
    end

    always_comb begin
        if (do_sub) begin
            word_sum = {1'b0, a} - {1'b0, b_eff};
            byte_sum = {1'b0, a[HALF_W-1:0]} - {1'b0, b_eff[HALF_W-1:0]};
        end else begin
            word_sum = {1'b0, a} + {1'b0, b_eff};
            byte_sum = {1'b0, a[HALF_W-1:0]} + {1'b0, b_eff[HALF_W-1:0]};
        end
        and_res = a & b;
    end

    always_comb begin
        if (is_word) begin
            arith_res = word_sum[DATA_W-1:0];
            carry_raw = word_sum[DATA_W];
        end else begin
            arith_res = {{(DATA_W-HALF_W){1'b0}}, byte_sum[HALF_W-1:0]};
            carry_raw = byte_sum[HALF_W];
        end
    end

    always_comb begin
        st = '0;
        if (!op_known) begin
            res = is_word ? a : {{(DATA_W-HALF_W){1'b0}}, a[HALF_W-1:0]};
        end else if (op == OP_AND) begin
            res = is_word ? and_res : {{(DATA_W-HALF_W){1'b0}}, and_res[HALF_W-1:0]};
        end else begin
            res       = arith_res;
            st.carry  = carry_raw;
            st.aux    = a[4] ^ b_eff[4] ^ arith_res[4];
            if (do_sub)
                st.ovf = (a[top] != b_eff[top]) && (arith_res[top] != a[top]);
            else
                st.ovf = (a[top] == b_eff[top]) && (arith_res[top] != a[top]);
        end
        st.sign   = res[top];
        st.zero   = (res == '0);
        st.parity = ~^res[7:0];
    end

endmodule

// File: rtl/alu_flag_merge.sv
module alu_flag_merge
    import alu_flags_pkg::*;
(
    input  logic [15:0]   flags_old,
    input  arith_status_t st,
    input  logic          op_known,
    input  logic          keep_carry,
    output logic [15:0]   flags_new
);
    always_comb begin
        flags_new = flags_old;
        if (op_known) begin
            flags_new[PF_POS] = st.parity;
            flags_new[AF_POS] = st.aux;
            flags_new[ZF_POS] = st.zero;
            flags_new[SF_POS] = st.sign;
            flags_new[OF_POS] = st.ovf;
            if (!keep_carry)
                flags_new[CF_POS] = st.carry;
        end
    end
endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
    import alu_flags_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        op,
    input  logic              is_word,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [15:0]       flags_in,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] result,
    output logic [15:0]       flags_out
);
    alu_state_e        state_q, state_d;
    logic [2:0]        op_q;
    logic              word_q;
    logic [DATA_W-1:0] a_q, b_q;
    logic [15:0]       fin_q;
    logic [DATA_W-1:0] calc_res;
    arith_status_t     calc_st;
    logic              calc_known, calc_keep_cf;
    logic [15:0]       calc_flags;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_CALC;
            ST_CALC: state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // operand capture and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q      <= '0;
            word_q    <= 1'b0;
            a_q       <= '0;
            b_q       <= '0;
            fin_q     <= '0;
            result    <= '0;
            flags_out <= '0;
            busy      <= 1'b0;
            done      <= 1'b0;
        end else begin
            busy <= (state_d != ST_IDLE);
            done <= (state_d == ST_DONE);
            unique case (state_q)
                ST_IDLE: if (start) begin
                    op_q   <= op;
                    word_q <= is_word;
                    a_q    <= opnd_a;
                    b_q    <= opnd_b;
                    fin_q  <= flags_in;
                end
                ST_CALC: begin
                    result    <= calc_res;
                    flags_out <= calc_flags;
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    alu_arith #(.DATA_W(DATA_W)) u_arith (
        .op         (op_q),
        .is_word    (word_q),
        .a          (a_q),
        .b          (b_q),
        .res        (calc_res),
        .st         (calc_st),
        .op_known   (calc_known),
        .keep_carry (calc_keep_cf)
    );

    alu_flag_merge u_merge (
        .flags_old  (fin_q),
        .st         (calc_st),
        .op_known   (calc_known),
        .keep_carry (calc_keep_cf),
        .flags_new  (calc_flags)
    );

endmodule

// File: rtl/alu_flags_unit_chk.sv
module alu_flags_unit_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [2:0]        op,
    input logic              is_word,
    input logic [15:0]       flags_in,
    input logic              busy,
    input logic              done,
    input logic [DATA_W-1:0] result,
    input logic [15:0]       flags_out
);
    localparam logic [15:0] PASS_MASK = 16'hF72A;

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R10
    ctrl_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((flags_out & PASS_MASK) == ($past(flags_in, 2) & PASS_MASK)));

    // R9
    byte_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !$past(is_word, 2)) |-> (result[DATA_W-1:8] == '0));

    // R8
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ($past(op, 2) <= 3'd4)) |-> (flags_out[6] == (result == '0)));

    // R8
    parity_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ($past(op, 2) <= 3'd4)) |-> (flags_out[2] == ~^result[7:0]));

    // R4
    and_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ($past(op, 2) == 3'd2)) |-> (!flags_out[0] && !flags_out[4] && !flags_out[11]));

    // R5
    incdec_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (($past(op, 2) == 3'd3) || ($past(op, 2) == 3'd4)))
            |-> (flags_out[0] == $past(flags_in[0], 2)));

    // R11
    unknown_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ($past(op, 2) > 3'd4)) |-> (flags_out == $past(flags_in, 2)));

    // R2
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

endmodule

bind alu_flags_unit alu_flags_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .op        (op),
    .is_word   (is_word),
    .flags_in  (flags_in),
    .busy      (busy),
    .done      (done),
    .result    (result),
    .flags_out (flags_out)
);

// File: tb/alu_flags_unit_tb.sv
module alu_flags_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = '0;
    logic        is_word = 1'b0;
    logic [15:0] opnd_a = '0, opnd_b = '0, flags_in = '0;
    logic        busy, done;
    logic [15:0] result, flags_out;

    int n_checks = 0;
    int n_errors = 0;
    int last_lat;

    always #2.5 clk = ~clk;

    alu_flags_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .is_word(is_word),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .flags_in(flags_in),
        .busy(busy), .done(done), .result(result), .flags_out(flags_out)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // independent integer model of the requirements
    function automatic logic [31:0] model(input int opc, input bit w, input int a_in,
                                          input int b_in, input logic [15:0] fin);
        int wd = w ? 16 : 8;
        int mask = (1 << wd) - 1;
        int msb = 1 << (wd - 1);
        int a = a_in & mask;
        int b = b_in & mask;
        int r, sa, sb, s;
        bit cf, af, ov;
        logic [15:0] f = fin;
        logic [15:0] r16;
        logic [7:0] lo;
        if (opc > 4) begin
            r16 = 16'(a);
            return {r16, fin};
        end
        if (opc == 3 || opc == 4) b = 1;
        sa = (a & msb) != 0 ? a - (1 << wd) : a;
        sb = (b & msb) != 0 ? b - (1 << wd) : b;
        cf = 0; af = 0; ov = 0;
        if (opc == 0 || opc == 3) begin
            r = a + b; cf = r > mask; af = ((a & 15) + (b & 15)) > 15;
            s = sa + sb; ov = (s > msb - 1) || (s < -msb);
        end else if (opc == 1 || opc == 4) begin
            r = a - b; cf = a < b; af = (a & 15) < (b & 15);
            s = sa - sb; ov = (s > msb - 1) || (s < -msb);
        end else begin
            r = a & b;
        end
        r = r & mask;
        r16 = 16'(r);
        lo = r16[7:0];
        f[11] = ov;
        f[7] = (r & msb) != 0;
        f[6] = (r == 0);
        f[4] = af;
        f[2] = ($countones(lo) % 2) == 0;
        if (!(opc == 3 || opc == 4)) f[0] = cf;
        return {r16, f};
    endfunction

    task automatic issue(input logic [2:0] o, input bit w, input logic [15:0] a,
                         input logic [15:0] b, input logic [15:0] f);
        @(negedge clk);
        op = o; is_word = w; opnd_a = a; opnd_b = b; flags_in = f; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        last_lat = 1;
        while (!done && last_lat < 20) begin
            @(negedge clk);
            last_lat++;
        end
    endtask

    task automatic run(input string tag, input logic [2:0] o, input bit w,
                       input logic [15:0] a, input logic [15:0] b, input logic [15:0] f);
        logic [31:0] e;
        e = model(int'(o), w, int'(a), int'(b), f);
        issue(o, w, a, b, f);
        chk({tag, " result"}, result, e[31:16]);
        chk({tag, " flags"}, flags_out, e[15:0]);
    endtask

    task automatic t_reset;
        chk("R1 busy", {15'b0, busy}, 16'h0);
        chk("R1 done", {15'b0, done}, 16'h0);
        chk("R1 result", result, 16'h0);
        chk("R1 flags", flags_out, 16'h0);
    endtask

    task automatic t_add;
        // hand-computed: 7FFF+1 -> 8000, PF AF SF OF set
        issue(3'd0, 1'b1, 16'h7FFF, 16'h0001, 16'h0000);
        chk("R7 add ovf result", result, 16'h8000);
        chk("R7 add ovf flags", flags_out, 16'h0894);
        run("R3 add carry", 3'd0, 1'b1, 16'hFFFF, 16'h0001, 16'h0000);
        run("R6 add nibble", 3'd0, 1'b1, 16'h1238, 16'h0009, 16'h0001);
        run("R3 add plain", 3'd0, 1'b1, 16'h1234, 16'h4321, 16'h0000);
    endtask

    task automatic t_sub;
        run("R3 sub borrow", 3'd1, 1'b1, 16'h0001, 16'h0002, 16'h0000);
        run("R7 sub ovf", 3'd1, 1'b1, 16'h8000, 16'h0001, 16'h0000);
        run("R8 sub zero", 3'd1, 1'b1, 16'h5A5A, 16'h5A5A, 16'h0801);
        run("R6 sub nibble", 3'd1, 1'b1, 16'h0010, 16'h0001, 16'h0000);
    endtask

    task automatic t_and;
        run("R4 and word", 3'd2, 1'b1, 16'hF0F3, 16'h8F31, 16'h0891);
        run("R4 and zero", 3'd2, 1'b1, 16'h00F0, 16'h0F0F, 16'h0011);
    endtask

    task automatic t_incdec;
        run("R5 inc cf kept 1", 3'd3, 1'b1, 16'hFFFF, 16'h1234, 16'h0001);
        run("R5 inc cf kept 0", 3'd3, 1'b1, 16'h7FFF, 16'h0000, 16'h0000);
        run("R5 dec zero", 3'd4, 1'b1, 16'h0001, 16'h0000, 16'h0001);
        run("R5 dec wrap", 3'd4, 1'b1, 16'h0000, 16'h0000, 16'h0000);
    endtask

    task automatic t_byte;
        // hand-computed: 00-01 at 8 bits -> FF, CF PF AF SF set
        issue(3'd1, 1'b0, 16'hAB00, 16'h0001, 16'h0000);
        chk("R9 byte sub result", result, 16'h00FF);
        chk("R9 byte sub flags", flags_out, 16'h0095);
        run("R9 byte add carry", 3'd0, 1'b0, 16'h12FF, 16'h3401, 16'h0000);
        run("R9 byte add ovf", 3'd0, 1'b0, 16'h007F, 16'h0001, 16'h0000);
        run("R9 byte inc", 3'd3, 1'b0, 16'h55FF, 16'h0000, 16'h0000);
        run("R8 word parity low byte", 3'd0, 1'b1, 16'h0100, 16'h0003, 16'h0000);
    endtask

    task automatic t_pass;
        run("R10 ctrl add", 3'd0, 1'b1, 16'h0011, 16'h0022, 16'hF72A);
        run("R10 ctrl and", 3'd2, 1'b0, 16'h00FF, 16'h00AA, 16'h0700);
        run("R10 ctrl dec", 3'd4, 1'b1, 16'h8000, 16'h0000, 16'hA828);
    endtask

    task automatic t_unknown;
        run("R11 op5", 3'd5, 1'b1, 16'hBEEF, 16'h1111, 16'h0ED5);
        run("R11 op7 byte", 3'd7, 1'b0, 16'hBEEF, 16'h1111, 16'h0041);
    endtask

    task automatic t_handshake;
        issue(3'd0, 1'b1, 16'h0002, 16'h0003, 16'h0000);
        chk("R2 latency", 16'(last_lat), 16'd2);
        @(negedge clk);
        chk("R2 done single", {15'b0, done}, 16'h0);
        // second start while busy must not alter the first result
        @(negedge clk);
        op = 3'd0; is_word = 1'b1; opnd_a = 16'h0100; opnd_b = 16'h0200;
        flags_in = 16'h0000; start = 1'b1;
        @(negedge clk);
        chk("R2 busy after start", {15'b0, busy}, 16'h1);
        op = 3'd1; opnd_a = 16'hFFFF; opnd_b = 16'h0001;
        @(negedge clk);
        start = 1'b0;
        chk("R2 done", {15'b0, done}, 16'h1);
        chk("R2 start ignored while busy", result, 16'h0300);
        @(negedge clk);
        chk("R2 idle after done", {15'b0, busy}, 16'h0);
        chk("R2 result held", result, 16'h0300);
    endtask

    initial begin : wdog
        repeat (50000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_add();
        t_sub();
        t_and();
        t_incdec();
        t_byte();
        t_pass();
        t_unknown();
        t_handshake();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule